// File: doc/BRIEF.md
# Serial Reference-Divider Configuration Port

This block receives a 16-bit configuration word over a three-wire serial link (serial clock, serial data, active-low enable) and turns it into the settings for a reference divider. The word has two fields. The top three bits select how the reference output is derived. This output-mode field is applied as soon as a complete word has been received. The lower thirteen bits set the divide ratio. The ratio passes through two storage stages, so the ratio the divider actually uses changes only when a separate commit pulse arrives.

All three serial inputs are brought into the system clock domain through synchronizer chains. Edges of the serial clock and of the enable are then detected in that domain. A write frame is one low period of the enable that contains exactly sixteen rising serial-clock edges, with data taken most significant bit first. A commit frame is one low period of the enable that contains no serial-clock edge and during which the serial clock stays low. Any other frame is discarded.

Top module: `refdiv_cfg_port`

## Requirements
- R1: After reset, the output mode is 6 (reference divided by 8), and both the pending ratio and the active ratio are 5.
- R2: While the enable is low, each rising serial-clock edge shifts one data bit in, most significant bit first. Word bits 15..13 form the output-mode field and bits 12..0 form the ratio field.
- R3: When the enable rises after exactly 16 serial-clock edges, the output mode takes the value of word bits 15..13 within a few system clock cycles.
- R4: That same enable rise loads word bits 12..0 into the pending ratio and leaves the active ratio unchanged.
- R5: When the enable rises after a frame with no serial-clock edge, and the serial clock is low at that moment, the pending ratio is copied into the active ratio. The pending ratio and the output mode stay unchanged.
- R6: When the enable rises after any edge count from 1 to 15, or after more than 16, the word is discarded and the mode, pending ratio and active ratio are all left unchanged.
- R7: A frame with no serial-clock edge during which the serial clock is held high commits nothing, and all outputs stay unchanged.
- R8: Serial-clock and data activity while the enable is high leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous to clk |
| ser_dat_i | input | 1 | Serial data, sampled on rising serial-clock edges |
| ser_en_n_i | input | 1 | Active-low frame enable |
| refout_mode_o | output | MODE_W (3) | Output-mode field currently applied |
| ratio_pend_o | output | RATIO_W (13) | Pending (first-stage) ratio |
| ratio_act_o | output | RATIO_W (13) | Active (second-stage) ratio used by the divider |

## Verification
The hardest cases to produce are frames that are almost valid. A commit frame and a frame held with the serial clock high differ only in the clock level while the enable is low. A 17-edge frame differs from a good write by only one edge. The stimulus covers these with directed frames that set the serial-clock level before the enable falls. It then mixes random writes, commits and wrong-length frames, from 1 to 15 edges and from 17 to 20, and checks all three outputs against a bench model after every frame. That model tracks the pending and active ratios separately, so a commit that was lost or that came too early shows up at the ports.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
   localparam logic [2:0] REFOUT_XTAL_OFF   = 3'd0;
   localparam logic [2:0] REFOUT_XTAL_ON    = 3'd1;
   localparam logic [2:0] REFOUT_LOW        = 3'd2;
   localparam logic [2:0] REFOUT_BUFFERED   = 3'd3;
   localparam logic [2:0] REFOUT_DIV2       = 3'd4;
   localparam logic [2:0] REFOUT_DIV4       = 3'd5;
   localparam logic [2:0] REFOUT_DIV8       = 3'd6;
   localparam logic [2:0] REFOUT_DIV16      = 3'd7;

   function automatic int unsigned cnt_width(input int unsigned n);
      return $clog2(n + 2);
   endfunction
endpackage

// File: rtl/refdiv_sync.sv
module refdiv_sync #(
   parameter int unsigned   WIDTH   = 1,
   parameter int unsigned   STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("refdiv_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/refdiv_shift.sv
module refdiv_shift #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sdat_s,
   input  logic              en_n_s,
   output logic [WORD_W-1:0] word_o,
   output logic              word_ok_o,
   output logic              commit_o
);
   localparam int unsigned CNT_W = refdiv_pkg::cnt_width(WORD_W);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

   logic              sclk_q, en_n_q;
   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] shreg;
   logic              sclk_rise, en_fall, en_rise;

   assign sclk_rise = sclk_s & ~sclk_q;
   assign en_fall   = ~en_n_s & en_n_q;
   assign en_rise   = en_n_s & ~en_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         en_n_q <= 1'b1;
         cnt    <= '0;
         shreg  <= '0;
      end else begin
         sclk_q <= sclk_s;
         en_n_q <= en_n_s;
         if (en_fall) begin
            cnt <= '0;
         end else if (!en_n_s && sclk_rise) begin
            shreg <= {shreg[WORD_W-2:0], sdat_s};
            if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
         end
      end
   end

   assign word_o    = shreg;
   assign word_ok_o = en_rise && (cnt == CNT_FULL);
   assign commit_o  = en_rise && (cnt == '0) && !sclk_s;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_OVER); // R6
   AST_IDLE_NOSHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (en_n_s && en_n_q) |=> $stable(shreg)); // R8
   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      !(word_ok_o && commit_o)); // R5
endmodule

// File: rtl/refdiv_bufs.sv
module refdiv_bufs #(
   parameter int unsigned       MODE_W    = 3,
   parameter int unsigned       RATIO_W   = 13,
   parameter logic [MODE_W-1:0]  MODE_RST  = '0,
   parameter logic [RATIO_W-1:0] RATIO_RST = '0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [MODE_W+RATIO_W-1:0] word_i,
   input  logic                      word_ok_i,
   input  logic                      commit_i,
   output logic [MODE_W-1:0]         mode_o,
   output logic [RATIO_W-1:0]        pend_o,
   output logic [RATIO_W-1:0]        act_o
);
   logic [MODE_W-1:0]  mode_q;
   logic [RATIO_W-1:0] pend_q, act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RST;
         pend_q <= RATIO_RST;
         act_q  <= RATIO_RST;
      end else begin
         if (word_ok_i) begin
            mode_q <= word_i[MODE_W+RATIO_W-1:RATIO_W];
            pend_q <= word_i[RATIO_W-1:0];
         end
         if (commit_i) act_q <= pend_q;
      end
   end

   assign mode_o = mode_q;
   assign pend_o = pend_q;
   assign act_o  = act_q;

   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !word_ok_i |=> $stable(mode_q)); // R3
   AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(act_q)); // R4
   AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |=> (act_q == $past(pend_q))); // R5
   AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |=> $stable(pend_q)); // R5
endmodule

// File: rtl/refdiv_cfg_port.sv
module refdiv_cfg_port #(
   parameter int unsigned        WORD_W      = 16,
   parameter int unsigned        MODE_W      = 3,
   parameter int unsigned        RATIO_W     = 13,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter logic [MODE_W-1:0]  MODE_RST    = refdiv_pkg::REFOUT_DIV8,
   parameter logic [RATIO_W-1:0] RATIO_RST   = 13'd5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk_i,
   input  logic               ser_dat_i,
   input  logic               ser_en_n_i,
   output logic [MODE_W-1:0]  refout_mode_o,
   output logic [RATIO_W-1:0] ratio_pend_o,
   output logic [RATIO_W-1:0] ratio_act_o
);
   if (WORD_W != MODE_W + RATIO_W) begin : g_bad_split
      $error("refdiv_cfg_port: WORD_W must equal MODE_W + RATIO_W");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("refdiv_cfg_port: WORD_W too small");
   end

   logic [2:0]        raw_bus, syn_bus;
   logic [WORD_W-1:0] word;
   logic              word_ok, commit;

   assign raw_bus = {ser_en_n_i, ser_dat_i, ser_clk_i};

   refdiv_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_bus),
      .q_o   (syn_bus)
   );

   refdiv_shift #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (syn_bus[0]),
      .sdat_s    (syn_bus[1]),
      .en_n_s    (syn_bus[2]),
      .word_o    (word),
      .word_ok_o (word_ok),
      .commit_o  (commit)
   );

   refdiv_bufs #(
      .MODE_W    (MODE_W),
      .RATIO_W   (RATIO_W),
      .MODE_RST  (MODE_RST),
      .RATIO_RST (RATIO_RST)
   ) u_bufs (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_i    (word),
      .word_ok_i (word_ok),
      .commit_i  (commit),
      .mode_o    (refout_mode_o),
      .pend_o    (ratio_pend_o),
      .act_o     (ratio_act_o)
   );

   AST_RST_MODE: assert property (@(posedge clk)
      $rose(rst_n) |-> (refout_mode_o == MODE_RST)); // R1
endmodule

// File: tb/refdiv_cfg_port_bench.sv
module refdiv_cfg_port_bench;
   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0;
   logic ser_dat = 1'b0;
   logic ser_en_n = 1'b1;
   logic [2:0]  mode;
   logic [12:0] pend, act;

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   logic [2:0]  exp_mode;
   logic [12:0] exp_pend, exp_act;

   always #5 clk = ~clk;

   refdiv_cfg_port u_refdiv_cfg_port (
      .clk           (clk),
      .rst_n         (rst_n),
      .ser_clk_i     (ser_clk),
      .ser_dat_i     (ser_dat),
      .ser_en_n_i    (ser_en_n),
      .refout_mode_o (mode),
      .ratio_pend_o  (pend),
      .ratio_act_o   (act)
   );

   function automatic logic [2:0] mode_of(input logic [15:0] w);
      return w[15:13];
   endfunction
   function automatic logic [12:0] ratio_of(input logic [15:0] w);
      return w[12:0];
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [15:0] actual, input logic [15:0] expect_v);
      checks++;
      if (actual !== expect_v) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, actual, expect_v);
      end
   endtask

   task automatic check_all(input string tag);
      check(tag, "mode",    {13'd0, mode}, {13'd0, exp_mode});
      check(tag, "pending", {3'd0, pend},  {3'd0, exp_pend});
      check(tag, "active",  {3'd0, act},   {3'd0, exp_act});
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame(input logic [15:0] w, input int nbits);
      ser_en_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < nbits; i++) begin
         if (nbits == 16) ser_dat = w[15-i];
         else             ser_dat = 1'($urandom);
         wait_clk(HALF);
         ser_clk = 1'b1;
         wait_clk(HALF);
         ser_clk = 1'b0;
         wait_clk(HALF);
      end
      ser_en_n = 1'b1;
      wait_clk(10);
      if (nbits == 16) begin
         exp_mode = mode_of(w);
         exp_pend = ratio_of(w);
      end
   endtask

   task automatic commit_pulse(input logic clk_level);
      ser_clk = clk_level;
      wait_clk(HALF);
      ser_en_n = 1'b0;
      wait_clk(HALF);
      ser_en_n = 1'b1;
      wait_clk(10);
      if (!clk_level) exp_act = exp_pend;
      ser_clk = 1'b0;
      wait_clk(HALF);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5EED_0042));
      exp_mode = 3'd6;
      exp_pend = 13'd5;
      exp_act  = 13'd5;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(3);
      check_all("R1");

      // R2: field split, MSB first
      frame(16'hA5C3, 16);
      check("R2", "mode",    {13'd0, mode}, 16'd5);
      check("R2", "pending", {3'd0, pend},  16'h05C3);
      // R4: active untouched by write
      check("R4", "active",  {3'd0, act},   16'd5);
      // R5: commit copies, pending stays
      commit_pulse(1'b0);
      check_all("R5");

      // R3/R4: second write, mode immediate, active held
      frame(16'h3FFF, 16);
      check_all("R3");
      // R7: commit with serial clock high ignored
      commit_pulse(1'b1);
      check_all("R7");
      // R6: 15 and 17 edges discarded
      frame(16'hFFFF, 15);
      check_all("R6");
      frame(16'h0000, 17);
      check_all("R6");
      // R8: activity while enable high
      for (int i = 0; i < 12; i++) begin
         ser_dat = 1'($urandom);
         ser_clk = 1'b1;
         wait_clk(HALF);
         ser_clk = 1'b0;
         wait_clk(HALF);
      end
      wait_clk(10);
      check_all("R8");
      commit_pulse(1'b0);
      check_all("R5");

      // random mix
      for (int k = 0; k < 150; k++) begin
         int sel;
         sel = int'($urandom_range(0, 9));
         if (sel < 5) begin
            frame(16'($urandom), 16);
            check_all("R3");
         end else if (sel < 8) begin
            commit_pulse(1'b0);
            check_all("R5");
         end else if (sel == 8) begin
            frame(16'($urandom), int'($urandom_range(1, 15)));
            check_all("R6");
         end else begin
            frame(16'($urandom), int'($urandom_range(17, 20)));
            check_all("R6");
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule